// File: doc/BRIEF.md
# CAN Controller Interrupt Flag Register

This block keeps the interrupt status of a mailbox-based CAN controller. The controller core sends it single-cycle event strobes: reset processing finished, a data or remote frame was stored in a given mailbox, and a dominant bit was seen on the bus. The block records each event as a flag in a 16-bit flag word. Software clears the flags through a register write port.

The block also holds a 16-bit interrupt mask register. It drives one registered interrupt request line built from the flags and the mask. The receive flag works differently from the others. A write does not clear it. It drops by itself once no mailbox with its receive interrupt enabled still has a frame pending. The reset flag always raises the request. The wake flag can only be set while the controller is asleep.

Top module: `canirq_flags`

## Requirements
- R1: After reset the flag word reads 0x0000, the mask reads 0xFEFF (all ones with bit 8 at 0) and the request line is 0.
- R2: Flag bit 9 becomes 1 on the clock edge where a frame-stored strobe names a mailbox whose `mb_mask` bit is 0. A frame stored into a mailbox whose `mb_mask` bit is 1 does not set it.
- R3: Flag bit 9 clears on any edge where `rx_pend & ~mb_mask` is zero and no unmasked frame is stored in that cycle. Otherwise it holds. Writes to bit 9 have no effect.
- R4: Flag bit 8 becomes 1 on a reset-done strobe. A flag write (`wr_sel` = 0) with data bit 8 at 1 clears it. With data bit 8 at 0 it holds.
- R5: Flag bit 4 becomes 1 on a dominant-bit strobe only while `in_sleep` is 1. A flag write with data bit 4 at 1 clears it. With data bit 4 at 0 it holds.
- R6: When a set event and a write-1 clear hit the same flag in the same cycle, the flag ends at 1.
- R7: Every flag bit other than 9, 8 and 4 always reads 0, whatever is written.
- R8: A write with `wr_sel` = 1 loads the mask from `wr_data`. Mask bit 8 always reads 0. Flag writes leave the mask unchanged.
- R9: The request line is registered. One edge after the flags, it equals bit 8 OR (bit 9 AND NOT mask bit 9) OR (bit 4 AND NOT mask bit 4). Bit 8 therefore raises it even when the mask is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_reset_done | input | 1 | Strobe: controller reset processing completed |
| evt_frame_stored | input | 1 | Strobe: a data or remote frame was stored |
| evt_frame_mbx | input | 4 | Mailbox index of the stored frame |
| evt_bus_dominant | input | 1 | Strobe: dominant bit detected on the bus |
| in_sleep | input | 1 | Controller is in sleep mode |
| rx_pend | input | 16 | Per-mailbox receive-pending bits |
| mb_mask | input | 16 | Per-mailbox receive interrupt mask (1 = disabled) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = flag word, 1 = mask |
| wr_data | input | 16 | Write data |
| flags_o | output | 16 | Flag word |
| mask_o | output | 16 | Mask register |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Every flag and mask result is due on the first clock edge after its stimulus. The request line is due one edge after that. The bench drives inputs on the falling edge and reads the flags and mask at the next falling edge. It reads the request line only after a second rising edge, and it also checks that the line is still low at the first falling edge. This pins down the latency exactly. Same-cycle set and clear collisions and mask-gated frames each get their own vectors.

// File: rtl/canirq_pkg.sv
// Shared constants for the CAN interrupt flag register.
// Bit positions are fixed because software decodes them.
package canirq_pkg;
    localparam int REG_W    = 16;
    localparam int BIT_RX   = 9;
    localparam int BIT_RST  = 8;
    localparam int BIT_WAKE = 4;

    typedef enum logic {
        SEL_FLAGS = 1'b0,
        SEL_MASK  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/canirq_w1c_flag.sv
// One event flag: set by a strobe, cleared by a write-1 request.
// Assumes set and clear are single-cycle. Set has priority over clear.
module canirq_w1c_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Flag storage; set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/canirq_rx_flag.sv
// Receive-message flag. Set by an unmasked frame store.
// Clears by itself when no enabled mailbox has a receive pending.
// Assumes the pending and mask vectors are valid every cycle.
module canirq_rx_flag #(
    parameter int NUM_MBX = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_i,
    input  logic [NUM_MBX-1:0] rx_pend,
    input  logic [NUM_MBX-1:0] mb_mask,
    output logic               flag_o
);
    logic none_enabled;

    // Clear condition: no mailbox with its interrupt enabled has a frame pending.
    always_comb none_enabled = ~|(rx_pend & ~mb_mask);

    // Flag storage; a new store wins over the clear condition.
    always_ff @(posedge clk) begin
        if (!rst_n)            flag_o <= 1'b0;
        else if (set_i)        flag_o <= 1'b1;
        else if (none_enabled) flag_o <= 1'b0;
    end
endmodule

// File: rtl/canirq_mask_reg.sv
// Interrupt mask register. Resets to all ones.
// Bit FIXED_BIT is hard-wired to 0 because that source cannot be masked.
module canirq_mask_reg #(
    parameter int W         = 16,
    parameter int FIXED_BIT = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] mask_o
);
    localparam logic [W-1:0] KEEP = ~(W'(1) << FIXED_BIT);

    // Mask storage with the fixed bit held at 0.
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_o <= KEEP;
        else if (wr_i) mask_o <= data_i & KEEP;
    end
endmodule

// File: rtl/canirq_req.sv
// Registered interrupt request: the unmaskable source ORed with the gated
// maskable sources. Adds one cycle of latency after the flags.
module canirq_req (
    input  logic clk,
    input  logic rst_n,
    input  logic hard_src,
    input  logic rx_src,
    input  logic rx_mask,
    input  logic wake_src,
    input  logic wake_mask,
    output logic irq_o
);
    // Request register.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= hard_src | (rx_src & ~rx_mask) | (wake_src & ~wake_mask);
    end
endmodule

// File: rtl/canirq_flags.sv
// CAN controller interrupt flag register (top).
// Records controller events as flags, lets software clear them through the
// write port, and drives one registered request line.
// Assumes the event strobes last one cycle and are synchronous to clk.
module canirq_flags
    import canirq_pkg::*;
#(
    parameter int NUM_MBX = 16,
    localparam int IDX_W  = $clog2(NUM_MBX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_reset_done,
    input  logic               evt_frame_stored,
    input  logic [IDX_W-1:0]   evt_frame_mbx,
    input  logic               evt_bus_dominant,
    input  logic               in_sleep,
    input  logic [NUM_MBX-1:0] rx_pend,
    input  logic [NUM_MBX-1:0] mb_mask,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   flags_o,
    output logic [REG_W-1:0]   mask_o,
    output logic               irq_o
);
    logic frame_set, wake_set, flag_wr, mask_wr;
    logic rx_q, rst_q, wake_q;

    // Decode the events and the write target.
    always_comb begin
        frame_set = evt_frame_stored & ~mb_mask[evt_frame_mbx];
        wake_set  = evt_bus_dominant & in_sleep;
        flag_wr   = wr_en & (reg_sel_e'(wr_sel) == SEL_FLAGS);
        mask_wr   = wr_en & (reg_sel_e'(wr_sel) == SEL_MASK);
    end

    canirq_rx_flag #(.NUM_MBX(NUM_MBX)) i_rx (
        .clk(clk), .rst_n(rst_n), .set_i(frame_set),
        .rx_pend(rx_pend), .mb_mask(mb_mask), .flag_o(rx_q)
    );

    canirq_w1c_flag i_rst (
        .clk(clk), .rst_n(rst_n), .set_i(evt_reset_done),
        .clr_i(flag_wr & wr_data[BIT_RST]), .flag_o(rst_q)
    );

    canirq_w1c_flag i_wake (
        .clk(clk), .rst_n(rst_n), .set_i(wake_set),
        .clr_i(flag_wr & wr_data[BIT_WAKE]), .flag_o(wake_q)
    );

    canirq_mask_reg #(.W(REG_W), .FIXED_BIT(BIT_RST)) i_mask (
        .clk(clk), .rst_n(rst_n), .wr_i(mask_wr),
        .data_i(wr_data), .mask_o(mask_o)
    );

    canirq_req i_req (
        .clk(clk), .rst_n(rst_n), .hard_src(rst_q),
        .rx_src(rx_q), .rx_mask(mask_o[BIT_RX]),
        .wake_src(wake_q), .wake_mask(mask_o[BIT_WAKE]),
        .irq_o(irq_o)
    );

    // Assemble the flag word; unimplemented bits read 0.
    always_comb begin
        flags_o           = '0;
        flags_o[BIT_RX]   = rx_q;
        flags_o[BIT_RST]  = rst_q;
        flags_o[BIT_WAKE] = wake_q;
    end
endmodule

// File: rtl/canirq_flags_chk.sv
// Property checker for canirq_flags, bound to every instance of it.
module canirq_flags_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        evt_reset_done,
    input logic        evt_frame_stored,
    input logic [3:0]  evt_frame_mbx,
    input logic        evt_bus_dominant,
    input logic        in_sleep,
    input logic [15:0] rx_pend,
    input logic [15:0] mb_mask,
    input logic        wr_en,
    input logic        wr_sel,
    input logic [15:0] wr_data,
    input logic [15:0] flags_o,
    input logic [15:0] mask_o,
    input logic        irq_o
);
    logic unmasked_store;
    always_comb unmasked_store = evt_frame_stored && !mb_mask[evt_frame_mbx];

    a_r2_rx_set: assert property (@(posedge clk) disable iff (!rst_n)
        unmasked_store |=> flags_o[9]);

    a_r3_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!unmasked_store && ((rx_pend & ~mb_mask) == 16'h0)) |=> !flags_o[9]);

    a_r4_rst_set: assert property (@(posedge clk) disable iff (!rst_n)
        evt_reset_done |=> flags_o[8]);

    a_r4_rst_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_data[8] && !evt_reset_done) |=> !flags_o[8]);

    a_r5_wake_only_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags_o[4] && !(evt_bus_dominant && in_sleep)) |=> !flags_o[4]);

    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o & 16'hFCEF) == 16'h0);

    a_r8_mask_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_o[8]);

    a_r9_hard_req: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[8] |=> irq_o);

    a_r9_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags_o[8] && !(flags_o[9] && !mask_o[9]) && !(flags_o[4] && !mask_o[4]))
        |=> !irq_o);
endmodule

bind canirq_flags canirq_flags_chk i_chk (.*);

// File: tb/test_canirq_flags.sv
`timescale 1ns/1ps
// Bench for canirq_flags: a vector table followed by directed tests.
module test_canirq_flags;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_reset_done = 1'b0, evt_frame_stored = 1'b0;
    logic [3:0]  evt_frame_mbx = '0;
    logic        evt_bus_dominant = 1'b0, in_sleep = 1'b0;
    logic [15:0] rx_pend = '0, mb_mask = '0;
    logic        wr_en = 1'b0, wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] flags_o, mask_o;
    logic        irq_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    canirq_flags i_canirq_flags (.*);

    typedef struct packed {
        logic        rst;
        logic        frm;
        logic [3:0]  idx;
        logic        dom;
        logic        slp;
        logic [15:0] pend;
        logic [15:0] mbm;
        logic        we;
        logic        ws;
        logic [15:0] wd;
        logic [15:0] expf;
        logic [3:0]  req;
    } vec_t;

    // Cumulative sequence; expf is the flag word after the edge.
    localparam vec_t VEC [14] = '{
        '{1'b1,1'b0,4'd0,1'b0,1'b0,16'h0000,16'h0000,1'b0,1'b0,16'h0000,16'h0100,4'd4}, // R4 set
        '{1'b0,1'b0,4'd0,1'b0,1'b0,16'h0000,16'h0000,1'b1,1'b0,16'h0100,16'h0000,4'd4}, // R4 clear
        '{1'b0,1'b1,4'd3,1'b0,1'b0,16'h0008,16'h0000,1'b0,1'b0,16'h0000,16'h0200,4'd2}, // R2 set
        '{1'b0,1'b0,4'd0,1'b0,1'b0,16'h0008,16'h0000,1'b0,1'b0,16'h0000,16'h0200,4'd3}, // R3 hold
        '{1'b0,1'b0,4'd0,1'b0,1'b0,16'h0008,16'h0000,1'b1,1'b0,16'h0200,16'h0200,4'd3}, // R3 write ignored
        '{1'b0,1'b0,4'd0,1'b0,1'b0,16'h0000,16'h0000,1'b0,1'b0,16'h0000,16'h0000,4'd3}, // R3 clear
        '{1'b0,1'b1,4'd5,1'b0,1'b0,16'h0020,16'h0020,1'b0,1'b0,16'h0000,16'h0000,4'd2}, // R2 masked store
        '{1'b0,1'b0,4'd0,1'b1,1'b0,16'h0000,16'h0000,1'b0,1'b0,16'h0000,16'h0000,4'd5}, // R5 awake
        '{1'b0,1'b0,4'd0,1'b1,1'b1,16'h0000,16'h0000,1'b0,1'b0,16'h0000,16'h0010,4'd5}, // R5 asleep
        '{1'b0,1'b0,4'd0,1'b0,1'b0,16'h0000,16'h0000,1'b1,1'b0,16'hFFEF,16'h0010,4'd7}, // R7 write 0 bit4
        '{1'b0,1'b0,4'd0,1'b1,1'b1,16'h0000,16'h0000,1'b1,1'b0,16'h0010,16'h0010,4'd6}, // R6 wake collision
        '{1'b0,1'b0,4'd0,1'b0,1'b0,16'h0000,16'h0000,1'b1,1'b0,16'h0010,16'h0000,4'd5}, // R5 clear
        '{1'b1,1'b0,4'd0,1'b0,1'b0,16'h0000,16'h0000,1'b1,1'b0,16'h0100,16'h0100,4'd6}, // R6 reset collision
        '{1'b0,1'b0,4'd0,1'b0,1'b0,16'h0000,16'h0000,1'b1,1'b0,16'hFFFF,16'h0000,4'd7}  // R7 all ones
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic quiet();
        evt_reset_done = 0; evt_frame_stored = 0; evt_frame_mbx = '0;
        evt_bus_dominant = 0; in_sleep = 0; wr_en = 0; wr_sel = 0; wr_data = '0;
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        #(200000 * 5.0);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flags", flags_o, 16'h0000);
        check("R1 mask", mask_o, 16'hFEFF);
        check("R1 irq", {15'h0, irq_o}, 16'h0000);

        foreach (VEC[i]) begin
            evt_reset_done   = VEC[i].rst;
            evt_frame_stored = VEC[i].frm;
            evt_frame_mbx    = VEC[i].idx;
            evt_bus_dominant = VEC[i].dom;
            in_sleep         = VEC[i].slp;
            rx_pend          = VEC[i].pend;
            mb_mask          = VEC[i].mbm;
            wr_en            = VEC[i].we;
            wr_sel           = VEC[i].ws;
            wr_data          = VEC[i].wd;
            tick();
            check($sformatf("R%0d vec%0d flags", VEC[i].req, i), flags_o, VEC[i].expf);
            quiet();
        end
        rx_pend = '0; mb_mask = '0;

        // R8: mask write, bit 8 stays 0
        wr_en = 1; wr_sel = 1; wr_data = 16'hFFFF; tick(); quiet();
        check("R8 mask bit8 fixed", mask_o, 16'hFEFF);
        wr_en = 1; wr_sel = 0; wr_data = 16'h0000; tick(); quiet();
        check("R8 flag write keeps mask", mask_o, 16'hFEFF);

        // R9: unmaskable reset flag, one-cycle latency
        evt_reset_done = 1; tick(); quiet();
        check("R9 irq latency", {15'h0, irq_o}, 16'h0000);
        tick();
        check("R9 unmaskable irq", {15'h0, irq_o}, 16'h0001);
        wr_en = 1; wr_data = 16'h0100; tick(); quiet();
        tick();
        check("R9 irq drops", {15'h0, irq_o}, 16'h0000);

        // R9: masked receive flag gives no request until unmasked
        evt_frame_stored = 1; evt_frame_mbx = 4'd0; rx_pend = 16'h0001; tick(); quiet();
        check("R2 mbx0 set", flags_o, 16'h0200);
        tick();
        check("R9 rx masked", {15'h0, irq_o}, 16'h0000);
        wr_en = 1; wr_sel = 1; wr_data = 16'h0000; tick(); quiet();
        check("R8 mask cleared", mask_o, 16'h0000);
        tick();
        check("R9 rx unmasked", {15'h0, irq_o}, 16'h0001);

        // R3: masking the pending mailbox at the mailbox level clears bit 9
        mb_mask = 16'h0001; tick();
        check("R3 mbmask clear", flags_o, 16'h0000);

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule